// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier

This unit multiplies two 8-bit operands in one of four modes: both operands unsigned, both signed, a signed first operand with an unsigned second, or unsigned with the product doubled. The doubled mode treats the operands as unsigned fractions. A one-cycle strobe starts an operation. Exactly two cycles later the unit returns a 16-bit result, split into a high byte and a low byte, together with a zero flag and a carry flag. The low byte is meant for the lower register of a fixed destination pair and the high byte for the upper one. No other status flag is produced.

The datapath has two register stages. The first stage captures the operands after extending them for the chosen mode. The second stage registers the product, the flags and a one-cycle done pulse. The control pins are plain strobes and the result side has no back-pressure. The result registers keep their value until the next operation completes, and the consumer must take the result in the cycle that done is high. While an operation is in flight the unit is busy, and a start seen in that cycle is dropped. At most one operation therefore starts every second cycle.

Top module: `mul8x8_unit`

## Requirements
- R1: Mode 2'b00 returns the unsigned product of opa and opb as a 16-bit value {res_hi, res_lo}.
- R2: Mode 2'b01 treats both operands as two's-complement numbers and returns the 16-bit two's-complement product.
- R3: Mode 2'b10 sign-extends only opa and zero-extends opb, and returns the 16-bit two's-complement product.
- R4: Mode 2'b11 returns the unsigned product shifted left by one bit, with bit 15 of the unshifted product discarded, so that res_lo bit 0 is always 0.
- R5: flag_c equals bit 15 of the 16-bit product taken before any fractional shift.
- R6: flag_z is 1 exactly when the final 16-bit result is zero.
- R7: When start is sampled high on a clock edge while the unit is idle, done is high for exactly one cycle after the second following edge, and the result and flags become valid in that same cycle.
- R8: A start sampled in the cycle after an accepted start is ignored: it produces no extra done pulse and does not change the result.
- R9: After reset, done, res_hi, res_lo, flag_z and flag_c are all 0.
- R10: The result and the flags hold their values in every cycle in which done is not being raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| mode | input | 2 | 00 unsigned, 01 signed, 10 signed by unsigned, 11 fractional |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| done | output | 1 | One-cycle pulse when a new result is valid |
| res_hi | output | 8 | High byte of the result |
| res_lo | output | 8 | Low byte of the result |
| flag_z | output | 1 | Zero flag of the result |
| flag_c | output | 1 | Carry flag: bit 15 of the unshifted product |

## Verification
The case that is hardest to reach from the ports is a start that arrives while the first stage still holds an operation. To reach it, the bench holds start high across two consecutive edges and changes the operands and the mode between the two edges. It then checks that only one done pulse appears and that the result belongs to the first operand pair. The mode boundaries also need specific operands to show up. A fractional product of 0x80 by 0x80 has carry 0 but a result bit 15 of 1, which separates the pre-shift carry from the post-shift carry. A mixed-sign product of 0x80 by 0xFF exposes any sign extension of the second operand.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
  typedef enum logic [1:0] {
    MM_UU = 2'b00,
    MM_SS = 2'b01,
    MM_SU = 2'b10,
    MM_FU = 2'b11
  } mul_mode_e;
endpackage

// File: rtl/mul8_seq_ctrl.sv
module mul8_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic stage1_vld,
  output logic done
);
  assign accept = start && !stage1_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_vld <= 1'b0;
      done       <= 1'b0;
    end else begin
      stage1_vld <= accept;
      done       <= stage1_vld;
    end
  end

  // R7: an operation in stage one finishes on the next edge
  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_vld |=> done);
  // R7: the done pulse lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: no new operation is taken while stage one is occupied
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
endmodule

// File: rtl/mul8_operand_prep.sv
module mul8_operand_prep
  import mul8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       mode,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic signed [W:0] xa,
  output logic signed [W:0] xb,
  output logic             frac
);
  logic a_signed, b_signed;
  logic [W:0] ext_a, ext_b;

  always_comb begin
    a_signed = (mode == MM_SS) || (mode == MM_SU);
    b_signed = (mode == MM_SS);
    ext_a = {a_signed & opa[W-1], opa};
    ext_b = {b_signed & opb[W-1], opb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xa   <= '0;
      xb   <= '0;
      frac <= 1'b0;
    end else if (load) begin
      xa   <= ext_a;
      xb   <= ext_b;
      frac <= (mode == MM_FU);
    end
  end

  // R3: in mixed mode the second operand always enters as non-negative
  assert_su_b_unsigned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == MM_SU) |=> !xb[W]);
endmodule

// File: rtl/mul8_core.sv
module mul8_core #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic signed [W:0] xa,
  input  logic signed [W:0] xb,
  input  logic              frac,
  output logic [2*W-1:0]    prod,
  output logic              flag_z,
  output logic              flag_c
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] ea, eb, raw;
  logic [PW-1:0] fin;

  always_comb begin
    ea  = PW'(xa);
    eb  = PW'(xb);
    raw = ea * eb;
    fin = frac ? {raw[PW-2:0], 1'b0} : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod   <= '0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (load) begin
      prod   <= fin;
      flag_z <= (fin == '0);
      flag_c <= raw[PW-1];
    end
  end

  // R4: a fractional result always has a clear least significant bit
  assert_frac_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && frac) |=> !prod[0]);
  // R10: the result registers stay put between operations
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(prod) && $stable(flag_z) && $stable(flag_c)));
endmodule

// File: rtl/mul8x8_unit.sv
module mul8x8_unit
  import mul8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_z,
  output logic         flag_c
);
  logic accept, stage1_vld, frac;
  logic signed [W:0] xa, xb;
  logic [2*W-1:0] prod;

  mul8_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .stage1_vld(stage1_vld), .done(done)
  );

  mul8_operand_prep #(.W(W)) u_prep (
    .clk(clk), .rst_n(rst_n), .load(accept), .mode(mode),
    .opa(opa), .opb(opb), .xa(xa), .xb(xb), .frac(frac)
  );

  mul8_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(stage1_vld), .xa(xa), .xb(xb),
    .frac(frac), .prod(prod), .flag_z(flag_z), .flag_c(flag_c)
  );

  assign res_hi = prod[2*W-1:W];
  assign res_lo = prod[W-1:0];

  // R6: the zero flag agrees with the bytes presented with done
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == ({res_hi, res_lo} == '0)));
endmodule

// File: tb/tb_mul8x8_unit.sv
module tb_mul8x8_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] opa = '0, opb = '0;
  logic done, flag_z, flag_c;
  logic [7:0] res_hi, res_lo;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mul8x8_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opa(opa), .opb(opb),
    .done(done), .res_hi(res_hi), .res_lo(res_lo), .flag_z(flag_z), .flag_c(flag_c)
  );

  // {mode, opa, opb, expected result, expected z, expected c}
  localparam logic [35:0] VEC [12] = '{
    {2'b00, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},
    {2'b00, 8'h00, 8'h37, 16'h0000, 1'b1, 1'b0},
    {2'b00, 8'h12, 8'h34, 16'h03A8, 1'b0, 1'b0},
    {2'b01, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0},
    {2'b01, 8'hFF, 8'h01, 16'hFFFF, 1'b0, 1'b1},
    {2'b01, 8'h7F, 8'h80, 16'hC080, 1'b0, 1'b1},
    {2'b10, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1},
    {2'b10, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},
    {2'b10, 8'h80, 8'hFF, 16'h8080, 1'b0, 1'b1},
    {2'b11, 8'hFF, 8'hFF, 16'hFC02, 1'b0, 1'b1},
    {2'b11, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
    {2'b11, 8'h40, 8'h02, 16'h0100, 1'b0, 1'b0}
  };

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // reference: {z, c, result}
  function automatic logic [17:0] ref_mul(logic [1:0] m, logic [7:0] a, logic [7:0] b);
    int ia, ib, p;
    logic [15:0] raw, res;
    ia = (m == 2'b01 || m == 2'b10) ? int'($signed(a)) : int'(a);
    ib = (m == 2'b01) ? int'($signed(b)) : int'(b);
    p = ia * ib;
    raw = p[15:0];
    res = (m == 2'b11) ? {raw[14:0], 1'b0} : raw;
    return {(res == 16'h0), raw[15], res};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts one operation and checks the result in the done cycle.
  task automatic run_op(logic [1:0] m, logic [7:0] a, logic [7:0] b,
                        logic [15:0] er, logic ez, logic ec);
    @(negedge clk);
    mode = m; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 no early done", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R7 done", {31'd0, done}, 32'd1);
    chk(mode_req(m), {16'd0, res_hi, res_lo}, {16'd0, er});
    chk("R5 carry", {31'd0, flag_c}, {31'd0, ec});
    chk("R6 zero", {31'd0, flag_z}, {31'd0, ez});
  endtask

  initial begin
    logic [17:0] e;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 done", {31'd0, done}, 32'd0);
    chk("R9 result", {16'd0, res_hi, res_lo}, 32'd0);
    chk("R9 flags", {30'd0, flag_z, flag_c}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++)
      run_op(VEC[i][35:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:2], VEC[i][1], VEC[i][0]);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      logic [7:0] a, b;
      m = 2'(i % 4);
      a = 8'($urandom);
      b = 8'($urandom);
      if (i % 50 == 0) a = 8'h00;
      e = ref_mul(m, a, b);
      run_op(m, a, b, e[15:0], e[17], e[16]);
    end

    // R8: start held across two edges; second operand set must be dropped
    e = ref_mul(2'b10, 8'h80, 8'hFF);
    @(negedge clk);
    mode = 2'b10; opa = 8'h80; opb = 8'hFF; start = 1'b1;
    @(negedge clk);
    mode = 2'b00; opa = 8'h03; opb = 8'h05;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done", {31'd0, done}, 32'd1);
    chk("R8 result", {16'd0, res_hi, res_lo}, {16'd0, e[15:0]});
    @(negedge clk);
    chk("R8 no second done", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R8 no second done late", {31'd0, done}, 32'd0);
    chk("R8 result kept", {16'd0, res_hi, res_lo}, {16'd0, e[15:0]});

    // R10: outputs held while idle and with operands changing
    held = {res_hi, res_lo};
    opa = 8'h55; opb = 8'hAA; mode = 2'b11;
    repeat (5) @(negedge clk);
    chk("R10 result held", {16'd0, res_hi, res_lo}, {16'd0, held});
    chk("R10 flags held", {30'd0, flag_z, flag_c}, {30'd0, e[17], e[16]});

    // R6: zero after a nonzero result, in fractional mode
    run_op(2'b11, 8'h00, 8'hFF, 16'h0000, 1'b1, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule